// File: doc/BRIEF.md
# Key-Protected Watchdog with Early-Warning Interrupt

The block is a watchdog peripheral with two clock domains. A bus domain holds the software-visible registers. A slow timebase domain runs a 32-bit down-counter that advances once per timebase tick. Software stores a 32-bit reset timeout and a 32-bit early-warning threshold, each as a pair of 16-bit halves. Control bits start the count, allow the warning interrupt and allow the reset request. When the remaining count steps onto the threshold, an interrupt becomes pending. When the count runs out, a reset request becomes pending.

All register writes are refused until software writes a 16-bit key to the key register. Writing any other value to the key register closes the block again. Each accepted write of a load half starts a toggle handshake that carries the load values into the timebase domain. While the handshake is in flight, a busy flag is raised. When a load completes, the counter restarts from the timeout value, so software kicks the watchdog by reloading it. The interrupt controller, the reset generator and clock gating are outside the block.

Reads have no back-pressure. A read strobe is accepted on every cycle, and its data appears with `bus_rvalid` exactly one cycle later. Writes are also accepted on every cycle.

Top module: `lockable_wdt`

Register offsets (bus_addr): 0x00 timeout low, 0x04 timeout high, 0x08 control, 0x0C clear, 0x10 status, 0x14 mask, 0x18 count low, 0x1C count high, 0x20 key, 0x2C threshold low, 0x30 threshold high.

## Requirements
- R1: After reset the block is locked. irq_o and rst_req_o are low. The status, control and key registers read 0.
- R2: A write of 0xE551 to offset 0x20 unlocks the block, and a write of any other value to 0x20 locks it. A read of 0x20 returns 1 in bit 0 while the block is unlocked and 0 while it is locked.
- R3: While the block is locked, a write to any offset other than 0x20 changes nothing: stored values, the pending bits and the outputs all stay as they were.
- R4: Offsets 0x00/0x04 hold the low/high 16 bits of the timeout, and 0x2C/0x30 hold the low/high 16 bits of the threshold. Each reads back as written.
- R5: Status bit 4 (busy) is set from the cycle after an accepted write to a load half until the new values are in the counter. After that, offsets 0x18/0x1C read the timeout value.
- R6: While control bit 1 is set, the counter decrements by one per timebase tick and stops at zero. While control bit 1 is clear, the counter holds its value.
- R7: Status bit 0 (pending interrupt) is set when the counter steps onto the threshold while control bit 0 is set. It is set once per pass and is not set while control bit 0 is clear.
- R8: Status bit 3 (pending reset) is set when the counter reaches zero while control bit 3 is set. rst_req_o follows status bit 3, and the counter stays at zero.
- R9: irq_o is high exactly when status bit 0 is set and mask bit 0 (offset 0x14) is clear.
- R10: An unlocked write to offset 0x0C with bit 0 set clears the pending interrupt. The same write with bit 3 set clears the pending reset.
- R11: A load that completes while the counter is running restarts the count from the new timeout value. This reload is the kick.
- R12: Every bus_rd is answered by bus_rvalid in the next cycle and by no other cycle. Control bits 3:0, including the stored mode bit 2, read back from offset 0x08.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus-domain clock |
| rst_n | input | 1 | Bus-domain asynchronous reset, active low |
| tb_clk | input | 1 | Timebase clock, one tick per count |
| tb_rst_n | input | 1 | Timebase-domain asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read response, one cycle after bus_rd |
| irq_o | output | 1 | Early-warning interrupt, level |
| rst_req_o | output | 1 | Reset request, level |

## Verification
The assertions check these properties on every cycle:
- A locked write never disturbs the stored state.
- A non-key value always locks the block.
- A clear of the reset bit takes effect.
- Busy rises after every accepted load write.
- Each read strobe gets its response.
- The counter holds while stopped and at zero.

Other behaviour depends on how the two clock domains line up, so only the bench's scenarios can show it:
- The warning fires once at the threshold and not again.
- The kick restarts a running count.
- The interrupt stays silent when it is disabled.
- The masked versus raw view of the pending interrupt behaves as required.

// File: rtl/lwdt_pkg.sv
package lwdt_pkg;
  localparam int HALF_W = 16;
  localparam int CNT_W  = 2 * HALF_W;
  localparam int ADDR_W = 6;
  localparam int CTRL_W = 4;

  localparam logic [ADDR_W-1:0] A_RLD_LO = 6'h00;
  localparam logic [ADDR_W-1:0] A_RLD_HI = 6'h04;
  localparam logic [ADDR_W-1:0] A_CTRL   = 6'h08;
  localparam logic [ADDR_W-1:0] A_CLR    = 6'h0C;
  localparam logic [ADDR_W-1:0] A_STAT   = 6'h10;
  localparam logic [ADDR_W-1:0] A_MASK   = 6'h14;
  localparam logic [ADDR_W-1:0] A_CNT_LO = 6'h18;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 6'h1C;
  localparam logic [ADDR_W-1:0] A_KEY    = 6'h20;
  localparam logic [ADDR_W-1:0] A_WRN_LO = 6'h2C;
  localparam logic [ADDR_W-1:0] A_WRN_HI = 6'h30;

  localparam logic [HALF_W-1:0] OPEN_CODE = 16'hE551;

  // control bit positions
  localparam int C_IRQ = 0;
  localparam int C_RUN = 1;
  localparam int C_MODE = 2;
  localparam int C_RST = 3;
  // status bit positions
  localparam int S_IRQ = 0;
  localparam int S_RST = 3;
  localparam int S_BUSY = 4;

  typedef struct packed {
    logic [CNT_W-1:0] reload;
    logic [CNT_W-1:0] warn;
  } load_t;
endpackage

// File: rtl/lwdt_sync.sv
module lwdt_sync #(
  parameter int W = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/lwdt_load_xfer.sv
module lwdt_load_xfer
  import lwdt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  kick,
  input  load_t src,
  output logic  busy,
  input  logic  tb_clk,
  input  logic  tb_rst_n,
  output load_t ld_val,
  output logic  load_evt
);
  logic  pend_q, infl_q, req_q, ack_s;
  logic  req_s, seen_q;
  load_t hold_q;

  wire launch = pend_q && !infl_q;

  lwdt_sync #(.W(1), .STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(clk), .rst_n(rst_n), .d(seen_q), .q(ack_s));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      infl_q <= 1'b0;
      req_q  <= 1'b0;
      hold_q <= '0;
    end else begin
      if (kick) pend_q <= 1'b1;
      else if (launch) pend_q <= 1'b0;
      if (launch) begin
        hold_q <= src;
        req_q  <= ~req_q;
        infl_q <= 1'b1;
      end else if (infl_q && (ack_s == req_q)) begin
        infl_q <= 1'b0;
      end
    end
  end

  assign busy = pend_q || infl_q;

  lwdt_sync #(.W(1), .STAGES(SYNC_STAGES)) u_req_sync (
    .clk(tb_clk), .rst_n(tb_rst_n), .d(req_q), .q(req_s));

  always_ff @(posedge tb_clk or negedge tb_rst_n) begin
    if (!tb_rst_n) seen_q <= 1'b0;
    else seen_q <= req_s;
  end

  assign load_evt = req_s ^ seen_q;
  assign ld_val = hold_q;

  // R5
  load_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> busy);
endmodule

// File: rtl/lwdt_tick_core.sv
module lwdt_tick_core
  import lwdt_pkg::*;
(
  input  logic             tb_clk,
  input  logic             tb_rst_n,
  input  logic             run,
  input  logic             load_evt,
  input  load_t            ld_val,
  output logic [CNT_W-1:0] cnt_gray,
  output logic             warn_tgl,
  output logic             exp_tgl
);
  logic [CNT_W-1:0] cnt_q, cnt_nx, warn_q;

  wire step     = run && (cnt_q != '0) && !load_evt;
  wire hit_warn = step && ((cnt_q - 1'b1) == warn_q);
  wire hit_exp  = step && (cnt_q == {{(CNT_W-1){1'b0}}, 1'b1});

  always_comb begin
    if (load_evt) cnt_nx = ld_val.reload;
    else if (step) cnt_nx = cnt_q - 1'b1;
    else cnt_nx = cnt_q;
  end

  always_ff @(posedge tb_clk or negedge tb_rst_n) begin
    if (!tb_rst_n) begin
      cnt_q    <= '0;
      cnt_gray <= '0;
      warn_q   <= '0;
      warn_tgl <= 1'b0;
      exp_tgl  <= 1'b0;
    end else begin
      cnt_q    <= cnt_nx;
      cnt_gray <= cnt_nx ^ (cnt_nx >> 1);
      if (load_evt) warn_q <= ld_val.warn;
      if (hit_warn) warn_tgl <= ~warn_tgl;
      if (hit_exp) exp_tgl <= ~exp_tgl;
    end
  end

  // R8
  zero_hold_chk: assert property (@(posedge tb_clk) disable iff (!tb_rst_n)
    (cnt_q == '0 && !load_evt) |=> (cnt_q == '0));
  // R6
  freeze_chk: assert property (@(posedge tb_clk) disable iff (!tb_rst_n)
    (!run && !load_evt) |=> $stable(cnt_q));
endmodule

// File: rtl/lwdt_regfile.sv
module lwdt_regfile
  import lwdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [HALF_W-1:0] bus_wdata,
  output logic [HALF_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  input  logic              warn_tgl_s,
  input  logic              exp_tgl_s,
  input  logic [CNT_W-1:0]  cnt_gray_s,
  input  logic              busy,
  output load_t             ld,
  output logic              load_kick,
  output logic              run,
  output logic              irq_o,
  output logic              rst_req_o
);
  logic              open_q, mask_q, pend_irq_q, pend_rst_q;
  logic              warn_prev_q, exp_prev_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  rld_q, wrn_q, cnt_bin;
  logic [HALF_W-1:0] rd_nx;

  function automatic logic [CNT_W-1:0] gray2bin(input logic [CNT_W-1:0] g);
    logic [CNT_W-1:0] b;
    b[CNT_W-1] = g[CNT_W-1];
    for (int i = CNT_W-2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  wire wr_ok    = bus_wr && open_q;
  wire warn_evt = warn_tgl_s ^ warn_prev_q;
  wire exp_evt  = exp_tgl_s ^ exp_prev_q;
  wire clr_hit  = wr_ok && (bus_addr == A_CLR);

  assign cnt_bin   = gray2bin(cnt_gray_s);
  assign load_kick = wr_ok && (bus_addr == A_RLD_LO || bus_addr == A_RLD_HI ||
                               bus_addr == A_WRN_LO || bus_addr == A_WRN_HI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q      <= 1'b0;
      mask_q      <= 1'b0;
      ctrl_q      <= '0;
      rld_q       <= '0;
      wrn_q       <= '0;
      pend_irq_q  <= 1'b0;
      pend_rst_q  <= 1'b0;
      warn_prev_q <= 1'b0;
      exp_prev_q  <= 1'b0;
    end else begin
      warn_prev_q <= warn_tgl_s;
      exp_prev_q  <= exp_tgl_s;
      if (bus_wr && bus_addr == A_KEY) open_q <= (bus_wdata == OPEN_CODE);
      if (wr_ok) begin
        case (bus_addr)
          A_RLD_LO: rld_q[HALF_W-1:0]     <= bus_wdata;
          A_RLD_HI: rld_q[CNT_W-1:HALF_W] <= bus_wdata;
          A_WRN_LO: wrn_q[HALF_W-1:0]     <= bus_wdata;
          A_WRN_HI: wrn_q[CNT_W-1:HALF_W] <= bus_wdata;
          A_CTRL:   ctrl_q <= bus_wdata[CTRL_W-1:0];
          A_MASK:   mask_q <= bus_wdata[0];
          default: ;
        endcase
      end
      if (warn_evt && ctrl_q[C_IRQ]) pend_irq_q <= 1'b1;
      else if (clr_hit && bus_wdata[S_IRQ]) pend_irq_q <= 1'b0;
      if (exp_evt && ctrl_q[C_RST]) pend_rst_q <= 1'b1;
      else if (clr_hit && bus_wdata[S_RST]) pend_rst_q <= 1'b0;
    end
  end

  always_comb begin
    rd_nx = '0;
    case (bus_addr)
      A_RLD_LO: rd_nx = rld_q[HALF_W-1:0];
      A_RLD_HI: rd_nx = rld_q[CNT_W-1:HALF_W];
      A_WRN_LO: rd_nx = wrn_q[HALF_W-1:0];
      A_WRN_HI: rd_nx = wrn_q[CNT_W-1:HALF_W];
      A_CTRL:   rd_nx[CTRL_W-1:0] = ctrl_q;
      A_MASK:   rd_nx[0] = mask_q;
      A_CNT_LO: rd_nx = cnt_bin[HALF_W-1:0];
      A_CNT_HI: rd_nx = cnt_bin[CNT_W-1:HALF_W];
      A_KEY:    rd_nx[0] = open_q;
      A_STAT: begin
        rd_nx[S_IRQ]  = pend_irq_q;
        rd_nx[S_RST]  = pend_rst_q;
        rd_nx[S_BUSY] = busy;
      end
      default: rd_nx = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_nx;
    end
  end

  assign ld        = '{reload: rld_q, warn: wrn_q};
  assign run       = ctrl_q[C_RUN];
  assign irq_o     = pend_irq_q && !mask_q;
  assign rst_req_o = pend_rst_q;

  // R3
  locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !open_q && bus_addr != A_KEY) |=>
      ($stable(ctrl_q) && $stable(rld_q) && $stable(wrn_q) && $stable(mask_q)));
  // R2
  relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_KEY && bus_wdata != OPEN_CODE) |=> !open_q);
  // R10
  clear_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hit && bus_wdata[S_RST] && !exp_evt) |=> !rst_req_o);
  // R12
  rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);
endmodule

// File: rtl/lockable_wdt.sv
module lockable_wdt
  import lwdt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tb_clk,
  input  logic              tb_rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [HALF_W-1:0] bus_wdata,
  output logic [HALF_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  output logic              irq_o,
  output logic              rst_req_o
);
  load_t            ld_bus, ld_val;
  logic             load_kick, busy, load_evt;
  logic             run_b, run_t;
  logic             warn_tgl, exp_tgl;
  logic [1:0]       evt_s;
  logic [CNT_W-1:0] cnt_gray, cnt_gray_s;

  lwdt_regfile u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .warn_tgl_s(evt_s[0]), .exp_tgl_s(evt_s[1]), .cnt_gray_s(cnt_gray_s),
    .busy(busy), .ld(ld_bus), .load_kick(load_kick), .run(run_b),
    .irq_o(irq_o), .rst_req_o(rst_req_o));

  lwdt_load_xfer #(.SYNC_STAGES(SYNC_STAGES)) u_xfer (
    .clk(clk), .rst_n(rst_n), .kick(load_kick), .src(ld_bus), .busy(busy),
    .tb_clk(tb_clk), .tb_rst_n(tb_rst_n), .ld_val(ld_val), .load_evt(load_evt));

  lwdt_sync #(.W(1), .STAGES(SYNC_STAGES)) u_run_sync (
    .clk(tb_clk), .rst_n(tb_rst_n), .d(run_b), .q(run_t));

  lwdt_tick_core u_core (
    .tb_clk(tb_clk), .tb_rst_n(tb_rst_n), .run(run_t),
    .load_evt(load_evt), .ld_val(ld_val),
    .cnt_gray(cnt_gray), .warn_tgl(warn_tgl), .exp_tgl(exp_tgl));

  lwdt_sync #(.W(2), .STAGES(SYNC_STAGES)) u_evt_sync (
    .clk(clk), .rst_n(rst_n), .d({exp_tgl, warn_tgl}), .q(evt_s));

  lwdt_sync #(.W(CNT_W), .STAGES(SYNC_STAGES)) u_cnt_sync (
    .clk(clk), .rst_n(rst_n), .d(cnt_gray), .q(cnt_gray_s));
endmodule

// File: tb/sim_lockable_wdt.sv
module sim_lockable_wdt;
  logic clk = 1'b0, tb_clk = 1'b0, rst_n = 1'b0, tb_rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [5:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic bus_rvalid, irq_o, rst_req_o;

  int nchk = 0, nerr = 0;
  bit raw_rd = 1'b0, done = 1'b0;
  logic [15:0] exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;
  always #20 tb_clk = ~tb_clk;

  lockable_wdt u0 (.clk(clk), .rst_n(rst_n), .tb_clk(tb_clk), .tb_rst_n(tb_rst_n),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .irq_o(irq_o), .rst_req_o(rst_req_o));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (bus_rvalid && !raw_rd) begin
      if (exp_q.size() == 0) check("R12", 32'h1, 32'h0);
      else check(tag_q.pop_front(), {16'h0, bus_rdata}, {16'h0, exp_q.pop_front()});
    end
  end

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd_exp(input logic [5:0] a, input logic [15:0] e, input string req);
    exp_q.push_back(e); tag_q.push_back(req);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic rd_raw(input logic [5:0] a, output logic [15:0] v);
    raw_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; v = bus_rdata;
    #1 raw_rd = 1'b0;
  endtask

  task automatic wait_idle();
    logic [15:0] s;
    for (int i = 0; i < 500; i++) begin
      rd_raw(6'h10, s);
      if (!s[4]) return;
    end
    check("R5", 32'h1, 32'h0);
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    logic [15:0] a, b;
    wait_cycles(5);
    rst_n = 1'b1; tb_rst_n = 1'b1;
    wait_cycles(5);
    // R1 reset state
    check("R1", irq_o, 0);
    check("R1", rst_req_o, 0);
    check("R12", bus_rvalid, 0);
    rd_exp(6'h10, 16'h0, "R1");
    rd_exp(6'h20, 16'h0, "R1");
    rd_exp(6'h08, 16'h0, "R1");
    // R3 locked writes dropped
    wr(6'h00, 16'h1234);
    wr(6'h08, 16'h000F);
    rd_exp(6'h00, 16'h0, "R3");
    rd_exp(6'h08, 16'h0, "R3");
    rd_exp(6'h10, 16'h0, "R3");
    // R2 unlock, R4 R5 load
    wr(6'h20, 16'hE551);
    rd_exp(6'h20, 16'h1, "R2");
    wr(6'h00, 16'd20);
    rd_exp(6'h10, 16'h0010, "R5");
    wr(6'h04, 16'h0);
    wr(6'h2C, 16'd8);
    wr(6'h30, 16'h0);
    wait_idle();
    rd_exp(6'h00, 16'd20, "R4");
    rd_exp(6'h2C, 16'd8, "R4");
    wait_cycles(10);
    rd_exp(6'h18, 16'd20, "R5");
    rd_exp(6'h1C, 16'h0, "R5");
    // R2 relock with non-key values
    wr(6'h20, 16'h0000);
    rd_exp(6'h20, 16'h0, "R2");
    wr(6'h20, 16'hE551);
    wr(6'h20, 16'hBEEF);
    rd_exp(6'h20, 16'h0, "R2");
    wr(6'h20, 16'hE551);
    // R12 control readback, start counting with everything enabled
    wr(6'h08, 16'h000F);
    rd_exp(6'h08, 16'h000F, "R12");
    for (int i = 0; i < 3000 && !irq_o; i++) @(negedge clk);
    check("R7", irq_o, 1);
    rd_raw(6'h18, a);
    check("R7", (a <= 16'd8 && a >= 16'd5), 1);
    rd_exp(6'h10, 16'h0001, "R7");
    // R9 mask
    wr(6'h14, 16'h1);
    check("R9", irq_o, 0);
    rd_exp(6'h10, 16'h0001, "R9");
    wr(6'h14, 16'h0);
    check("R9", irq_o, 1);
    // R10 clear interrupt
    wr(6'h0C, 16'h0001);
    check("R10", irq_o, 0);
    rd_exp(6'h10, 16'h0000, "R10");
    // R8 expiry
    for (int i = 0; i < 3000 && !rst_req_o; i++) @(negedge clk);
    check("R8", rst_req_o, 1);
    wait_cycles(50);
    rd_exp(6'h18, 16'h0, "R8");
    rd_exp(6'h10, 16'h0008, "R7");
    // R3 locked clear ignored
    wr(6'h20, 16'h0);
    wr(6'h0C, 16'h0008);
    check("R3", rst_req_o, 1);
    wr(6'h20, 16'hE551);
    wr(6'h0C, 16'h0008);
    check("R10", rst_req_o, 0);
    rd_exp(6'h10, 16'h0, "R10");
    // R6 freeze
    wr(6'h08, 16'h0001);
    wr(6'h00, 16'd50);
    wait_idle();
    wait_cycles(40);
    rd_exp(6'h18, 16'd50, "R6");
    wait_cycles(200);
    rd_exp(6'h18, 16'd50, "R6");
    // R11 kick while running, interrupt and reset disabled
    wr(6'h08, 16'h0002);
    wait_cycles(200);
    rd_raw(6'h18, a);
    check("R6", (a < 16'd50 && a > 16'd20), 1);
    wr(6'h00, 16'd50);
    wait_idle();
    wait_cycles(6);
    rd_raw(6'h18, b);
    check("R11", (b >= 16'd47 && b > a), 1);
    wait_cycles(800);
    rd_exp(6'h18, 16'h0, "R6");
    rd_exp(6'h10, 16'h0, "R7");
    check("R8", rst_req_o, 0);
    // R4 high halves reach the counter
    wr(6'h08, 16'h0000);
    wr(6'h04, 16'h0001);
    wr(6'h00, 16'h0003);
    wait_idle();
    wait_cycles(10);
    rd_exp(6'h1C, 16'h0001, "R4");
    rd_exp(6'h18, 16'h0003, "R4");
    wait_cycles(5);
    check("R12", exp_q.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule